// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. It steers the input switches of an external analog integrator and watches that integrator's comparator. A conversion has three phases. The integrator is first held shorted for a programmable settling time. It then charges from the unknown input for a programmable number of clock cycles. The block then switches the integrator to a reference of opposite polarity and counts clock cycles until the comparator reports that the integrator has come back to its starting level. That count, taken with the same clock that timed the charge phase, is the conversion result. The result is proportional to the ratio of the unknown input to the reference.

The charge length is an input, so it can be set to a whole number of mains periods, which rejects line-frequency noise. The comparator passes through a two-flop synchronizer, and the two extra cycles this adds are removed from the count. A programmable ceiling on the discharge count ends a conversion whose input is too large: the result is saturated and an overrange flag is set. The configuration inputs must stay stable while a conversion is running.

Top module: `dual_slope_adc_ctrl`

## Requirements
- R1: After reset, all three switch outputs, `busy`, `result_valid`, `overrange` and `result` are 0.
- R2: A `start` pulse seen while idle begins a conversion. `sw_zero` is high for max(`az_len`,1) cycles. Then `sw_input` is high for max(`int_len`,1) cycles. Then `sw_ref` is high until the conversion ends.
- R3: No more than one of `sw_zero`, `sw_input` and `sw_ref` is high in any cycle, and the reference phase always follows the input phase directly.
- R4: `cmp_in` high means the integrator is at or below its starting level. `result` is the number of reference-phase cycles that complete before the first cycle in which `cmp_in` is high. The two synchronizer cycles are not included. For the bench integrator this equals ceil(T·vin/vref), where T is the charge length.
- R5: If that count would exceed `deint_max`, `result` becomes `deint_max` and `overrange` becomes 1. A count exactly equal to `deint_max` is a normal result with `overrange` 0.
- R6: `result_valid` is high for exactly one cycle: the cycle right after `sw_ref` falls. `result` and `overrange` keep their values until the next conversion finishes. `busy` is low in the cycle after the pulse.
- R7: A `start` pulse while `busy` is high is ignored. The running phase lengths and result do not change, and no second conversion follows.
- R8: `busy` is high from the cycle after an accepted `start` through the `result_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times both slopes |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a conversion |
| cmp_in | input | 1 | Asynchronous integrator comparator, high at or below the start level |
| az_len | input | CW | Zeroing phase length in cycles |
| int_len | input | CW | Charge phase length in cycles |
| deint_max | input | CW | Largest allowed discharge count |
| sw_zero | output | 1 | Shorts the integrator |
| sw_input | output | 1 | Connects the unknown input |
| sw_ref | output | 1 | Connects the reference |
| busy | output | 1 | Conversion in progress |
| result | output | CW | Discharge count |
| result_valid | output | 1 | One-cycle completion strobe |
| overrange | output | 1 | Last result was saturated |

## Verification
The bench drives a cycle-accurate integrator model. It aims at the count boundaries. A zero input must give 0; if the synchronizer compensation were missing or off by one, this would read 2 or would wrap below zero. A discharge exactly at the ceiling must not be flagged, and one count past it must saturate; a comparison off by one would flag the first case or report 101. A start poked in the middle of the charge phase must neither lengthen that phase nor chain a second conversion. A phase length of zero must still give one cycle, where a bare counter compare would wrap and run for 65536 cycles.

// File: rtl/dual_slope_adc_ctrl.sv
module dual_slope_adc_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_in,
  input  logic [CW-1:0] az_len,
  input  logic [CW-1:0] int_len,
  input  logic [CW-1:0] deint_max,
  output logic          sw_zero,
  output logic          sw_input,
  output logic          sw_ref,
  output logic          busy,
  output logic [CW-1:0] result,
  output logic          result_valid,
  output logic          overrange
);
  localparam int SYNC_LAT = 2;

  typedef enum logic [2:0] {S_IDLE, S_ZERO, S_INT, S_DEINT, S_DONE} state_t;

  state_t        state;
  logic [CW:0]   cnt;
  logic          cmp_s1, cmp_s2;

  wire [CW:0] cnt_nx   = cnt + 1'b1;
  wire        zero_end = cnt_nx >= {1'b0, az_len};
  wire        int_end  = cnt_nx >= {1'b0, int_len};
  wire        trip     = cmp_s2 && (cnt >= (CW+1)'(SYNC_LAT));
  wire        ceiling  = cnt == ({1'b0, deint_max} + (CW+1)'(SYNC_LAT));

  assign sw_zero      = state == S_ZERO;
  assign sw_input     = state == S_INT;
  assign sw_ref       = state == S_DEINT;
  assign result_valid = state == S_DONE;
  assign busy         = state != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_s1 <= 1'b0;
      cmp_s2 <= 1'b0;
    end else begin
      cmp_s1 <= cmp_in;
      cmp_s2 <= cmp_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      result    <= '0;
      overrange <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start) state <= S_ZERO;
        end
        S_ZERO: begin
          if (zero_end) begin
            state <= S_INT;
            cnt   <= '0;
          end else cnt <= cnt_nx;
        end
        S_INT: begin
          if (int_end) begin
            state <= S_DEINT;
            cnt   <= '0;
          end else cnt <= cnt_nx;
        end
        S_DEINT: begin
          if (trip) begin
            result    <= cnt[CW-1:0] - CW'(SYNC_LAT);
            overrange <= 1'b0;
            state     <= S_DONE;
          end else if (ceiling) begin
            result    <= deint_max;
            overrange <= 1'b1;
            state     <= S_DONE;
          end else cnt <= cnt_nx;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_slope_adc_ctrl_chk.sv
module dual_slope_adc_ctrl_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] deint_max,
  input logic          sw_zero,
  input logic          sw_input,
  input logic          sw_ref,
  input logic          busy,
  input logic [CW-1:0] result,
  input logic          result_valid,
  input logic          overrange
);
  // R3
  switch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_zero, sw_input, sw_ref}));

  // R3
  ref_after_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ref) |-> $past(sw_input));

  // R6
  valid_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_ref) |-> result_valid);

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> (!result_valid && !busy));

  // R5
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && overrange) |-> (result == deint_max));

  // R7
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_zero) |-> $past(!busy && start));

  // R8
  busy_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_zero || sw_input || sw_ref || result_valid) |-> busy);
endmodule

bind dual_slope_adc_ctrl dual_slope_adc_ctrl_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_dual_slope_adc_ctrl.sv
module tb_dual_slope_adc_ctrl;
  localparam int CLK_NS = 10;
  localparam int CW = 16;
  localparam int NVEC = 7;
  // az_len, int_len, vin, vref, deint_max
  localparam int VEC [NVEC][5] = '{
    '{4, 10, 30, 10, 100},
    '{2, 20, 7, 3, 200},
    '{0, 8, 0, 5, 50},
    '{3, 16, 25, 4, 100},
    '{3, 16, 26, 4, 100},
    '{1, 50, 13, 13, 60},
    '{5, 5, 100, 1, 1000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] az_len = '0, int_len = '0, deint_max = '0;
  logic sw_zero, sw_input, sw_ref, busy, result_valid, overrange;
  logic [CW-1:0] result;

  int errors = 0, checks = 0;
  int mvin = 0, mvref = 1;
  longint acc = 0;
  logic cmp_in;

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n || sw_zero) acc <= 0;
    else if (sw_input) acc <= acc + mvin;
    else if (sw_ref) acc <= acc - mvref;
  end
  assign cmp_in = (acc <= 0);

  dual_slope_adc_ctrl #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .az_len(az_len), .int_len(int_len), .deint_max(deint_max),
    .sw_zero(sw_zero), .sw_input(sw_input), .sw_ref(sw_ref), .busy(busy),
    .result(result), .result_valid(result_valid), .overrange(overrange));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic convert(input int a, input int ti, input int vi, input int vr,
                         input int m, input bit poke);
    int nz = 0, ni = 0, nv = 0, guard = 0, res = 0, ovr = 0, busy_after = 0;
    int ea, ei, d, er, eo;
    bit done = 0;
    az_len = CW'(a); int_len = CW'(ti); deint_max = CW'(m);
    mvin = vi; mvref = vr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 20000) begin
      guard++;
      if (sw_zero) nz++;
      if (sw_input) ni++;
      if (!busy) begin
        check(1'b0, "R8 busy low mid-conversion", 0, 1);
        done = 1;
      end
      if (result_valid) begin
        nv++;
        res = int'(result);
        ovr = int'(overrange);
        done = 1;
      end
      start = (poke && sw_input && ni == 3);
      @(negedge clk);
      start = 1'b0;
    end
    if (result_valid) nv++;
    busy_after = int'(busy);
    ea = (a < 1) ? 1 : a;
    ei = (ti < 1) ? 1 : ti;
    d  = (ei * vi + vr - 1) / vr;
    er = (d > m) ? m : d;
    eo = (d > m) ? 1 : 0;
    check(nz == ea, "R2 zero phase cycles", nz, ea);
    check(ni == ei, poke ? "R7 input phase cycles with start poke" : "R2 input phase cycles", ni, ei);
    check(res == er, eo ? "R5 saturated result" : "R4 result count", res, er);
    check(ovr == eo, "R5 overrange flag", ovr, eo);
    check(nv == 1, "R6 valid pulse width", nv, 1);
    check(busy_after == 0, "R6 busy after valid", busy_after, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({sw_zero, sw_input, sw_ref, busy, result_valid, overrange} == 6'b0,
          "R1 outputs in reset", {sw_zero, sw_input, sw_ref, busy, result_valid, overrange}, 0);
    check(result == '0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !sw_zero, "R1 idle after reset", busy, 0);

    for (int k = 0; k < NVEC; k++)
      convert(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4], 1'b0);

    // R7 start pulse during the input phase
    convert(2, 12, 9, 4, 100, 1'b1);
    for (int k = 0; k < 5; k++) begin
      check(!busy, "R7 no chained conversion", busy, 0);
      @(negedge clk);
    end
    // R6 result holds while idle
    check(result == 16'd27, "R6 result held", result, 27);
    check(!overrange, "R6 overrange held low", overrange, 0);

    // R5 one past the ceiling after a normal result
    convert(1, 11, 10, 1, 109, 1'b0);
    // R4 zero charge length clamps to one cycle
    convert(1, 0, 6, 3, 20, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule